// File: doc/BRIEF.md
# Processor Idle-State Sequencer

This block tracks which idle power state a processor occupies, from full run (C0) through halt (C1) down to the deepest sleep (C4). It drives the sideband lines that put the processor into that state. The sleep state is requested in one of two ways. The processor can read one of three level registers, and the decode logic outside this block turns each read into a one-cycle pulse. The processor can also raise an auto-halt indication. A break event from outside returns the machine to full run.

Two configuration bits change the sequencing. The first, when set, makes a Level 3 read go straight to the deepest state instead of C3. The second lets bus-master snoop demand pull a deep state (C3 or C4) up to C2 for a while. The machine remembers which deep state it left, and it goes back there once the snoop demand has gone.

The sideband lines are raised one step per hold interval, in a fixed order: stop-clock first, then CPU clock-stop, then the deeper-sleep force, then the voltage-reduction pair. They are lowered in the reverse order. The state code changes at once. The lines then follow it as a ramp. A break that arrives part way through an entry turns the ramp back towards zero from wherever it stands.

Top module: `cstate_ctrl`

## Requirements
- R1: During and after reset the state code is 0 and every sideband output is low. State codes are C0=0, C1=1, C2=2, C3=3, C4=4.
- R2: In C0, auto_halt moves the machine to C1 on the next clock. C1 is left only on brk_evt.
- R3: In C0, an lvl2_rd pulse moves the machine to C2 on the next clock.
- R4: In C0, an lvl3_rd pulse moves the machine to C3 when c4_on_c3_en is 0, and to C4 when c4_on_c3_en is 1.
- R5: In C0, an lvl4_rd pulse moves the machine to C4 on the next clock.
- R6: In C3 or C4, snoop_req together with snoop_promo_en moves the machine to C2 on the next clock. If snoop_promo_en is 0, the machine stays in its deep state.
- R7: A C2 entered through R6 returns to the remembered C3 or C4 on the clock after snoop_req falls. A C2 entered by an lvl2_rd read ignores snoop_req. A break clears the memory.
- R8: brk_evt in any of C1 to C4 gives state 0 on the next clock. In C0, brk_evt blocks every request in that same cycle.
- R9: When several requests arrive together in C0, the precedence is lvl4_rd, then lvl3_rd, then lvl2_rd, then auto_halt.
- R10: Level reads and auto_halt have no effect in any state other than C0.
- R11: The steady output level depends on the state. In C1 and C2 only stpclk_req is high. In C3, stpclk_req and cpu_clk_stop are high. In C4, all outputs are high, including both vr_reduce bits.
- R12: The output level moves one step per clock (STEP_HOLD=1) towards the level of the current state. Entry raises the lines in the order stpclk_req, cpu_clk_stop, deep_sleep_force, vr_reduce. Exit lowers them in the reverse order. The first step follows the state change by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl2_rd | input | 1 | One-cycle pulse: Level 2 register read |
| lvl3_rd | input | 1 | One-cycle pulse: Level 3 register read |
| lvl4_rd | input | 1 | One-cycle pulse: Level 4 register read |
| auto_halt | input | 1 | Processor auto-halt indication |
| snoop_req | input | 1 | Bus masters need snoops |
| c4_on_c3_en | input | 1 | Map a Level 3 read to C4 |
| snoop_promo_en | input | 1 | Allow snoop demand to lift C3/C4 to C2 |
| brk_evt | input | 1 | Break event, return to C0 |
| stpclk_req | output | 1 | Stop-clock request (halt instruction stream) |
| cpu_clk_stop | output | 1 | Processor clock stop |
| deep_sleep_force | output | 1 | Force deeper sleep |
| vr_reduce | output | VR_W | Voltage-reduction controls |
| cur_state | output | 3 | Current state code |

## Verification
Two pairs of functions can fall in the same cycle. A break can meet a level read while the machine is in C0. A break can also meet the snoop-demotion condition while it is in C3, C4 or the temporary C2. The bench drives brk_evt in the same cycle as lvl4_rd, as snoop_req with promotion enabled, and as a half-finished entry ramp. A behavioural reference model, updated on every clock, decides the expected state code and output level. The bench compares them at each falling edge, so a lost break priority or a ramp that skips a step shows up as a mismatch in that very cycle.

// File: rtl/cstate_pkg.sv
package cstate_pkg;

   typedef enum logic [2:0] {
      CS_C0 = 3'd0,
      CS_C1 = 3'd1,
      CS_C2 = 3'd2,
      CS_C3 = 3'd3,
      CS_C4 = 3'd4
   } cstate_e;

   localparam int unsigned LVL_W   = 3;
   localparam int unsigned LVL_MAX = 4;

   // steady output depth demanded by a state
   function automatic logic [LVL_W-1:0] depth_of(input cstate_e s);
      logic [LVL_W-1:0] d;
      unique case (s)
         CS_C0:          d = 3'd0;
         CS_C1, CS_C2:   d = 3'd1;
         CS_C3:          d = 3'd2;
         CS_C4:          d = 3'd4;
         default:        d = 3'd0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/cstate_req_arb.sv
module cstate_req_arb
   import cstate_pkg::*;
(
   input  logic    lvl2_rd,
   input  logic    lvl3_rd,
   input  logic    lvl4_rd,
   input  logic    auto_halt,
   input  logic    c4_on_c3_en,
   output logic    req_vld,
   output cstate_e req_state
);

   always_comb begin
      req_vld   = 1'b1;
      req_state = CS_C0;
      if (lvl4_rd) begin
         req_state = CS_C4;
      end else if (lvl3_rd) begin
         req_state = c4_on_c3_en ? CS_C4 : CS_C3;
      end else if (lvl2_rd) begin
         req_state = CS_C2;
      end else if (auto_halt) begin
         req_state = CS_C1;
      end else begin
         req_vld   = 1'b0;
      end
   end

endmodule

// File: rtl/cstate_fsm.sv
module cstate_fsm
   import cstate_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req_vld,
   input  cstate_e req_state,
   input  logic    snoop_req,
   input  logic    snoop_promo_en,
   input  logic    brk_evt,
   output cstate_e state_q
);

   cstate_e state_d;
   logic    temp_q, temp_d;
   cstate_e deep_q, deep_d;
   logic    is_deep;

   assign is_deep = (state_q == CS_C3) || (state_q == CS_C4);

   always_comb begin
      state_d = state_q;
      temp_d  = temp_q;
      deep_d  = deep_q;
      unique case (state_q)
         CS_C0: begin
            temp_d = 1'b0;
            if (!brk_evt && req_vld) state_d = req_state;
         end
         CS_C1: begin
            if (brk_evt) state_d = CS_C0;
         end
         CS_C2: begin
            if (brk_evt) begin
               state_d = CS_C0;
               temp_d  = 1'b0;
            end else if (temp_q && !snoop_req) begin
               state_d = deep_q;
               temp_d  = 1'b0;
            end
         end
         CS_C3, CS_C4: begin
            if (brk_evt) begin
               state_d = CS_C0;
               temp_d  = 1'b0;
            end else if (snoop_req && snoop_promo_en) begin
               state_d = CS_C2;
               temp_d  = 1'b1;
               deep_d  = state_q;
            end
         end
         default: begin
            state_d = CS_C0;
            temp_d  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CS_C0;
         temp_q  <= 1'b0;
         deep_q  <= CS_C3;
      end else begin
         state_q <= state_d;
         temp_q  <= temp_d;
         deep_q  <= deep_d;
      end
   end

   AST_BRK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != CS_C0 && brk_evt) |=> (state_q == CS_C0)); // R8
   AST_BRK_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CS_C0 && brk_evt) |=> (state_q == CS_C0)); // R8
   AST_C1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CS_C1 && !brk_evt) |=> (state_q == CS_C1)); // R2
   AST_SNOOP_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
      (is_deep && snoop_req && snoop_promo_en && !brk_evt) |=> (state_q == CS_C2)); // R6
   AST_TEMP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_q && state_q == CS_C2 && !snoop_req && !brk_evt) |=> (state_q == $past(deep_q))); // R7
   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q <= CS_C4)); // R1

endmodule

// File: rtl/cstate_ramp.sv
module cstate_ramp
   import cstate_pkg::*;
#(
   parameter int unsigned STEP_HOLD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] target,
   output logic [LVL_W-1:0] lvl_q
);

   logic step_en;

   generate
      if (STEP_HOLD == 1) begin : g_nohold
         assign step_en = 1'b1;
      end else begin : g_hold
         localparam int unsigned CNT_W = $clog2(STEP_HOLD);
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_HOLD - 1);
         logic [CNT_W-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                hold_q <= '0;
            else if (lvl_q == target)  hold_q <= '0;
            else if (hold_q == CNT_LAST) hold_q <= '0;
            else                       hold_q <= hold_q + 1'b1;
         end
         assign step_en = (hold_q == CNT_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
      end else if (step_en) begin
         if (lvl_q < target)      lvl_q <= lvl_q + 1'b1;
         else if (lvl_q > target) lvl_q <= lvl_q - 1'b1;
      end
   end

   AST_RAMP_UP_TOWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q > $past(lvl_q)) |-> ($past(target) > $past(lvl_q))); // R12
   AST_RAMP_DN_TOWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q < $past(lvl_q)) |-> ($past(target) < $past(lvl_q))); // R12
   AST_RAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q <= LVL_W'(LVL_MAX))); // R11

endmodule

// File: rtl/cstate_ctrl.sv
module cstate_ctrl
   import cstate_pkg::*;
#(
   parameter int unsigned VR_W      = 2,
   parameter int unsigned STEP_HOLD = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lvl2_rd,
   input  logic            lvl3_rd,
   input  logic            lvl4_rd,
   input  logic            auto_halt,
   input  logic            snoop_req,
   input  logic            c4_on_c3_en,
   input  logic            snoop_promo_en,
   input  logic            brk_evt,
   output logic            stpclk_req,
   output logic            cpu_clk_stop,
   output logic            deep_sleep_force,
   output logic [VR_W-1:0] vr_reduce,
   output logic [2:0]      cur_state
);

   localparam logic [LVL_W-1:0] LV_STP  = 3'd1;
   localparam logic [LVL_W-1:0] LV_CPU  = 3'd2;
   localparam logic [LVL_W-1:0] LV_DEEP = 3'd3;
   localparam logic [LVL_W-1:0] LV_VR   = 3'd4;

   generate
      if (VR_W < 1) begin : g_bad_vr
         initial $fatal(1, "cstate_ctrl: VR_W must be at least 1");
      end
      if (STEP_HOLD < 1) begin : g_bad_hold
         initial $fatal(1, "cstate_ctrl: STEP_HOLD must be at least 1");
      end
   endgenerate

   logic             req_vld;
   cstate_e          req_state;
   cstate_e          state_q;
   logic [LVL_W-1:0] lvl;

   cstate_req_arb u_arb (
      .lvl2_rd     (lvl2_rd),
      .lvl3_rd     (lvl3_rd),
      .lvl4_rd     (lvl4_rd),
      .auto_halt   (auto_halt),
      .c4_on_c3_en (c4_on_c3_en),
      .req_vld     (req_vld),
      .req_state   (req_state)
   );

   cstate_fsm u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_vld        (req_vld),
      .req_state      (req_state),
      .snoop_req      (snoop_req),
      .snoop_promo_en (snoop_promo_en),
      .brk_evt        (brk_evt),
      .state_q        (state_q)
   );

   cstate_ramp #(.STEP_HOLD(STEP_HOLD)) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .target (depth_of(state_q)),
      .lvl_q  (lvl)
   );

   assign stpclk_req       = (lvl >= LV_STP);
   assign cpu_clk_stop     = (lvl >= LV_CPU);
   assign deep_sleep_force = (lvl >= LV_DEEP);
   assign cur_state        = state_q;

   generate
      for (genvar i = 0; i < VR_W; i++) begin : g_vr
         assign vr_reduce[i] = (lvl >= LV_VR);
      end
   endgenerate

   AST_CPU_AFTER_STP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_clk_stop) |-> $past(stpclk_req)); // R12
   AST_DEEP_AFTER_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deep_sleep_force) |-> $past(cpu_clk_stop)); // R12
   AST_VR_AFTER_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vr_reduce[0]) |-> $past(deep_sleep_force)); // R12
   AST_STP_LAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stpclk_req) |-> !$past(cpu_clk_stop)); // R12
   AST_C0_NO_STP: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_state == 3'd0 && $past(cur_state) == 3'd0 && !$past(stpclk_req)) |-> !stpclk_req); // R11

endmodule

// File: tb/tb_cstate_ctrl.sv
`timescale 1ns/1ps
module tb_cstate_ctrl;

   localparam int VR_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lvl2_rd = 0, lvl3_rd = 0, lvl4_rd = 0, auto_halt = 0;
   logic snoop_req = 0, c4_on_c3_en = 0, snoop_promo_en = 0, brk_evt = 0;
   logic stpclk_req, cpu_clk_stop, deep_sleep_force;
   logic [VR_W-1:0] vr_reduce;
   logic [2:0] cur_state;

   always #2.5 clk = ~clk;

   cstate_ctrl #(.VR_W(VR_W), .STEP_HOLD(1)) dut (
      .clk(clk), .rst_n(rst_n),
      .lvl2_rd(lvl2_rd), .lvl3_rd(lvl3_rd), .lvl4_rd(lvl4_rd),
      .auto_halt(auto_halt), .snoop_req(snoop_req),
      .c4_on_c3_en(c4_on_c3_en), .snoop_promo_en(snoop_promo_en),
      .brk_evt(brk_evt),
      .stpclk_req(stpclk_req), .cpu_clk_stop(cpu_clk_stop),
      .deep_sleep_force(deep_sleep_force), .vr_reduce(vr_reduce),
      .cur_state(cur_state)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // behavioural reference model
   int    m_st = 0, m_lvl = 0, m_mem = 0;
   bit    m_tmp = 0;
   string m_tag = "R1";

   always @(posedge clk) begin
      int tgt;
      if (!rst_n) begin
         m_st = 0; m_lvl = 0; m_tmp = 0; m_mem = 0; m_tag = "R1";
      end else begin
         tgt = (m_st == 0) ? 0 : (m_st <= 2) ? 1 : (m_st == 3) ? 2 : 4;
         if (m_lvl < tgt) m_lvl++;
         else if (m_lvl > tgt) m_lvl--;
         if (m_st == 0) begin
            m_tmp = 0;
            if (brk_evt)        begin m_tag = "R8"; end
            else if (lvl4_rd)   begin m_st = 4; m_tag = "R5"; end
            else if (lvl3_rd)   begin m_st = c4_on_c3_en ? 4 : 3; m_tag = "R4"; end
            else if (lvl2_rd)   begin m_st = 2; m_tag = "R3"; end
            else if (auto_halt) begin m_st = 1; m_tag = "R2"; end
         end else if (brk_evt) begin
            m_st = 0; m_tmp = 0; m_tag = "R8";
         end else if (m_st == 2 && m_tmp && !snoop_req) begin
            m_st = m_mem; m_tmp = 0; m_tag = "R7";
         end else if ((m_st == 3 || m_st == 4) && snoop_req && snoop_promo_en) begin
            m_mem = m_st; m_st = 2; m_tmp = 1; m_tag = "R6";
         end else begin
            m_tag = "R10";
         end
      end
   end

   task automatic chk(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int outs_now();
      return {stpclk_req, cpu_clk_stop, deep_sleep_force, vr_reduce};
   endfunction

   function automatic int outs_of(input int l);
      return {l >= 1, l >= 2, l >= 3, {VR_W{l >= 4}}};
   endfunction

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         chk(cur_state, m_st, m_tag);
         chk(outs_now(), outs_of(m_lvl), "R12");
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse(input bit l2, input bit l3, input bit l4, input bit h, input bit b);
      lvl2_rd = l2; lvl3_rd = l3; lvl4_rd = l4; auto_halt = h; brk_evt = b;
      @(negedge clk);
      lvl2_rd = 0; lvl3_rd = 0; lvl4_rd = 0; auto_halt = 0; brk_evt = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      cyc(3);
      chk(cur_state, 0, "R1");
      chk(outs_now(), 0, "R1");
      rst_n = 1;
      cyc(2);

      // C1 by auto-halt, reads ignored there
      pulse(0, 0, 0, 1, 0);
      chk(cur_state, 1, "R2");
      cyc(3);
      pulse(1, 1, 1, 1, 0);
      chk(cur_state, 1, "R10");
      chk(outs_now(), outs_of(1), "R11");
      pulse(0, 0, 0, 0, 1);
      chk(cur_state, 0, "R8");
      cyc(3);

      // simultaneous requests: L3 beats L2 and halt
      pulse(1, 1, 0, 1, 0);
      chk(cur_state, 3, "R9");
      cyc(4);
      chk(outs_now(), outs_of(2), "R11");
      pulse(0, 0, 0, 0, 1);
      cyc(4);

      // L3 remapped to C4, snoop demotion and return
      c4_on_c3_en = 1;
      pulse(0, 1, 0, 0, 0);
      chk(cur_state, 4, "R4");
      cyc(6);
      chk(outs_now(), outs_of(4), "R11");
      snoop_req = 1;
      cyc(3);
      chk(cur_state, 4, "R6");
      snoop_promo_en = 1;
      @(negedge clk);
      chk(cur_state, 2, "R6");
      cyc(5);
      chk(outs_now(), outs_of(1), "R12");
      snoop_req = 0;
      @(negedge clk);
      chk(cur_state, 4, "R7");
      pulse(0, 0, 0, 0, 1);
      chk(cur_state, 0, "R8");
      cyc(6);
      c4_on_c3_en = 0;

      // plain C2 ignores snoop
      pulse(1, 0, 0, 0, 0);
      chk(cur_state, 2, "R3");
      snoop_req = 1;
      cyc(2);
      snoop_req = 0;
      cyc(2);
      chk(cur_state, 2, "R7");
      pulse(0, 0, 0, 0, 1);
      cyc(3);

      // L4 with break mid-ramp
      pulse(0, 0, 1, 0, 0);
      chk(cur_state, 5 - 1, "R5");
      cyc(2);
      chk(outs_now(), outs_of(2), "R12");
      pulse(0, 0, 0, 0, 1);
      chk(cur_state, 0, "R8");
      chk(outs_now(), outs_of(3), "R12");
      cyc(3);
      chk(outs_now(), 0, "R12");

      // break together with a read in C0
      pulse(0, 0, 1, 0, 1);
      chk(cur_state, 0, "R8");
      cyc(2);

      // L3 to C3, demote, break in temporary C2 clears memory
      pulse(0, 1, 0, 0, 0);
      chk(cur_state, 3, "R4");
      snoop_req = 1;
      @(negedge clk);
      chk(cur_state, 2, "R6");
      pulse(0, 0, 0, 0, 1);
      chk(cur_state, 0, "R8");
      snoop_req = 0;
      cyc(5);
      pulse(1, 0, 0, 0, 0);
      cyc(3);
      chk(cur_state, 2, "R7");
      pulse(0, 0, 0, 0, 1);
      cyc(4);

      finish_run();
   end

endmodule